// File: doc/BRIEF.md
# EPP Host Port Controller

This block is the host side of an enhanced parallel port, attached to a simple request/acknowledge I/O bus. A request carries a 3-bit register offset. Offsets 0, 1 and 2 are plain standard-port registers: the data latch, status and control. They complete at once and never touch the handshake lines. Offset 3 runs an address-strobe cycle and offset 4 runs a data-strobe cycle, as a read or a write depending on `bus_we`. Offsets 5 to 7 read as zero and ignore writes.

For a handshake cycle the controller first waits for the peripheral's Wait line to read low. It then pulls the matching strobe low and keeps it low until Wait reads high. After that it raises the strobe, and only then acknowledges the host. A slow peripheral stretches the access by holding Wait low. A watchdog runs from the moment the request is accepted. If no answer arrives within `TIMEOUT_CYC` clocks, it aborts the access and latches a timeout flag in status bit 0. Software clears that flag by writing a 1 to it.

All inputs from the port (data, status pins and Wait) pass through two-flop synchronizers before the state machine uses them. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `epp_host_port`

## Requirements
- R1: While reset is asserted: both strobes and the write line are high, `bus_ack` is low, `port_ctrl` is zero, `port_data_oe` is zero, and status bit 0 reads 0 after release.
- R2: A request at offset 0, 1, 2, 5, 6 or 7 is acknowledged in the first cycle after the accepting clock edge, and it drives no strobe low. A read at offset 0 returns the synchronized `port_data_in`. Offsets 5 to 7 read 0x00, and writes to them change nothing.
- R3: Offset 3 pulses only `port_astb_n` and offset 4 pulses only `port_dstb_n`. The two strobes are never low together. `port_write_n` is low for writes and high for reads.
- R4: A strobe goes low only after the synchronized Wait has been seen low. While Wait stays high, no strobe is issued.
- R5: After the synchronized Wait is seen high, the strobe returns high before `bus_ack` rises. `bus_ack` is a single-cycle pulse, and both strobes are high whenever it is asserted.
- R6: In a handshake write, `port_data_out` equals the host write data and `port_data_oe` is 1. Both of these and `port_write_n` hold steady for the whole strobe-low interval.
- R7: A handshake read returns the synchronized `port_data_in` captured on the clock edge where Wait is seen high. `port_data_oe` is 0 during it.
- R8: Holding Wait low longer stretches the access cycle for cycle. Delaying the Wait response by D clocks delays `bus_ack` by exactly D clocks, and the timeout flag stays clear.
- R9: If the handshake does not finish, `bus_ack` rises in the cycle that begins `TIMEOUT_CYC`+1 rising edges after the accepting edge. Status bit 0 then reads 1, and a read in that case returns all ones.
- R10: The status register reads {synchronized `port_stat_in`[4:0] in bits 7:3, zeros in bits 2:1, timeout flag in bit 0}. Writing 1 to bit 0 clears the flag, and writing 0 leaves it set.
- R11: The control register (offset 2) is read/write and drives `port_ctrl`. While idle, the data pins carry the offset-0 data latch, with `port_data_oe` = NOT control bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Host access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_offs | input | 3 | Register offset |
| bus_wdata | input | DW | Host write data |
| bus_rdata | output | DW | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | One-cycle completion pulse |
| port_data_out | output | DW | Port data pins, outgoing value |
| port_data_oe | output | 1 | Port data output enable |
| port_data_in | input | DW | Port data pins, incoming value |
| port_stat_in | input | DW-3 | Peripheral status pins |
| port_ctrl | output | DW | Control register contents |
| port_wait | input | 1 | Peripheral handshake (Wait) |
| port_write_n | output | 1 | Transfer direction, low = write |
| port_astb_n | output | 1 | Address strobe, active low |
| port_dstb_n | output | 1 | Data strobe, active low |

## Verification
If the state machine jumps to the wrong state, it shows within a cycle or two. A strobe may fall while Wait is still high, or `bus_ack` may appear while a strobe is low. The acknowledge latency may also drift from its fixed pipeline value. A wrong watchdog count moves the abort acknowledge away from `TIMEOUT_CYC`+2 bench cycles, and a stale timeout flag shows in the next status read. The sweeps cover every byte through both strobes in both directions, so a corrupted write register or read capture shows up as a byte mismatch on the very transfer it affects.

// File: rtl/epp_host_pkg.sv
package epp_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_STROBE,
    ST_RELEASE,
    ST_ABORT,
    ST_ACK
  } epp_state_e;

  localparam logic [2:0] OFFS_LATCH = 3'd0;
  localparam logic [2:0] OFFS_STAT  = 3'd1;
  localparam logic [2:0] OFFS_CTRL  = 3'd2;
  localparam logic [2:0] OFFS_ADDR  = 3'd3;
  localparam logic [2:0] OFFS_DATA  = 3'd4;

  localparam int DIR_BIT = 5;

  function automatic logic is_hs_offs(input logic [2:0] offs);
    return (offs == OFFS_ADDR) || (offs == OFFS_DATA);
  endfunction

endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
    end
  end

  assign sync_out = sync_q;

endmodule

// File: rtl/epp_watchdog.sv
module epp_watchdog #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign expired = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (!expired) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R9: the count never passes the limit
  assert_wdog_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R9: once stopped, the count is back at zero on the next edge
  assert_wdog_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/epp_regs.sv
module epp_regs
  import epp_host_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    offs,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_data_s,
  input  logic [DW-4:0] pin_stat_s,
  input  logic          set_timeout,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] latch_q,
  output logic [DW-1:0] ctrl_q,
  output logic          timeout_q
);

  logic [DW-1:0] latch_d;
  logic [DW-1:0] ctrl_d;
  logic          timeout_d;
  logic          clr_timeout;

  assign clr_timeout = wr_en && (offs == OFFS_STAT) && wdata[0];

  always_comb begin
    latch_d   = latch_q;
    ctrl_d    = ctrl_q;
    timeout_d = timeout_q;
    if (wr_en && (offs == OFFS_LATCH)) latch_d = wdata;
    if (wr_en && (offs == OFFS_CTRL))  ctrl_d  = wdata;
    if (set_timeout) begin
      timeout_d = 1'b1;
    end else if (clr_timeout) begin
      timeout_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q   <= '0;
      ctrl_q    <= '0;
      timeout_q <= 1'b0;
    end else begin
      latch_q   <= latch_d;
      ctrl_q    <= ctrl_d;
      timeout_q <= timeout_d;
    end
  end

  always_comb begin
    case (offs)
      OFFS_LATCH: rdata = pin_data_s;
      OFFS_STAT:  rdata = {pin_stat_s, 2'b00, timeout_q};
      OFFS_CTRL:  rdata = ctrl_q;
      default:    rdata = '0;
    endcase
  end

  // R9: the flag rises only after an abort from the sequencer
  assert_flag_set_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_q) |-> $past(set_timeout));

  // R10: the flag falls only after a write of 1 to status bit 0
  assert_flag_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(timeout_q) |-> $past(wr_en && (offs == OFFS_STAT) && wdata[0]));

endmodule

// File: rtl/epp_host_port.sv
module epp_host_port
  import epp_host_pkg::*;
#(
  parameter int DW          = 8,
  parameter int TIMEOUT_CYC = 500
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [2:0]    bus_offs,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_ack,
  output logic [DW-1:0] port_data_out,
  output logic          port_data_oe,
  input  logic [DW-1:0] port_data_in,
  input  logic [DW-4:0] port_stat_in,
  output logic [DW-1:0] port_ctrl,
  input  logic          port_wait,
  output logic          port_write_n,
  output logic          port_astb_n,
  output logic          port_dstb_n
);

  localparam int SW = DW - 3;
  localparam int YW = DW + SW + 1;

  // reset release synchronizer
  logic rst_meta_q;
  logic rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_int  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_int  <= rst_meta_q;
    end
  end

  // port input synchronizers
  logic [YW-1:0] pins_s;
  logic [DW-1:0] data_s;
  logic [SW-1:0] stat_s;
  logic          wait_s;

  epp_sync #(.WIDTH(YW)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .async_in ({port_wait, port_stat_in, port_data_in}),
    .sync_out (pins_s)
  );

  assign data_s = pins_s[DW-1:0];
  assign stat_s = pins_s[DW+SW-1:DW];
  assign wait_s = pins_s[YW-1];

  // sequencer state
  epp_state_e    state_q, state_d;
  logic [2:0]    cur_offs_q, cur_offs_d;
  logic          cur_we_q, cur_we_d;
  logic [DW-1:0] cur_wdata_q, cur_wdata_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          accept;
  logic          hs_req;
  logic          wd_run;
  logic          wd_expired;

  assign accept = (state_q == ST_IDLE) && bus_req;
  assign hs_req = is_hs_offs(bus_offs);
  assign wd_run = (state_q == ST_ARM) || (state_q == ST_STROBE);

  epp_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .run     (wd_run),
    .expired (wd_expired)
  );

  // register file
  logic          reg_wr;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] latch_q;
  logic [DW-1:0] ctrl_q;
  logic          timeout_q;

  assign reg_wr = accept && !hs_req && bus_we;

  epp_regs #(.DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .wr_en       (reg_wr),
    .offs        (bus_offs),
    .wdata       (bus_wdata),
    .pin_data_s  (data_s),
    .pin_stat_s  (stat_s),
    .set_timeout (state_q == ST_ABORT),
    .rdata       (reg_rdata),
    .latch_q     (latch_q),
    .ctrl_q      (ctrl_q),
    .timeout_q   (timeout_q)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cur_offs_d  = cur_offs_q;
    cur_we_d    = cur_we_q;
    cur_wdata_d = cur_wdata_q;
    rdata_d     = rdata_q;
    case (state_q)
      ST_IDLE: begin
        if (bus_req) begin
          cur_offs_d  = bus_offs;
          cur_we_d    = bus_we;
          cur_wdata_d = bus_wdata;
          if (hs_req) begin
            state_d = ST_ARM;
          end else begin
            state_d = ST_ACK;
            if (!bus_we) rdata_d = reg_rdata;
          end
        end
      end
      ST_ARM: begin
        if (wd_expired) begin
          state_d = ST_ABORT;
        end else if (!wait_s) begin
          state_d = ST_STROBE;
        end
      end
      ST_STROBE: begin
        if (wait_s) begin
          state_d = ST_RELEASE;
          if (!cur_we_q) rdata_d = data_s;
        end else if (wd_expired) begin
          state_d = ST_ABORT;
        end
      end
      ST_RELEASE: state_d = ST_ACK;
      ST_ABORT: begin
        state_d = ST_ACK;
        if (!cur_we_q) rdata_d = '1;
      end
      ST_ACK:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q     <= ST_IDLE;
      cur_offs_q  <= '0;
      cur_we_q    <= 1'b0;
      cur_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      state_q     <= state_d;
      cur_offs_q  <= cur_offs_d;
      cur_we_q    <= cur_we_d;
      cur_wdata_q <= cur_wdata_d;
      rdata_q     <= rdata_d;
    end
  end

  // registered port outputs
  logic          hs_phase_d;
  logic          wr_phase_d;
  logic          astb_n_d, dstb_n_d, write_n_d, oe_d;
  logic [DW-1:0] dout_d;
  logic          astb_n_q, dstb_n_q, write_n_q, oe_q;
  logic [DW-1:0] dout_q;

  always_comb begin
    hs_phase_d = (state_d == ST_ARM) || (state_d == ST_STROBE) ||
                 (state_d == ST_RELEASE);
    wr_phase_d = hs_phase_d && cur_we_d;
    astb_n_d   = !((state_d == ST_STROBE) && (cur_offs_d == OFFS_ADDR));
    dstb_n_d   = !((state_d == ST_STROBE) && (cur_offs_d == OFFS_DATA));
    write_n_d  = !wr_phase_d;
    dout_d     = wr_phase_d ? cur_wdata_d : latch_q;
    oe_d       = hs_phase_d ? cur_we_d : !ctrl_q[DIR_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      astb_n_q  <= 1'b1;
      dstb_n_q  <= 1'b1;
      write_n_q <= 1'b1;
      oe_q      <= 1'b0;
      dout_q    <= '0;
    end else begin
      astb_n_q  <= astb_n_d;
      dstb_n_q  <= dstb_n_d;
      write_n_q <= write_n_d;
      oe_q      <= oe_d;
      dout_q    <= dout_d;
    end
  end

  assign bus_ack       = (state_q == ST_ACK);
  assign bus_rdata     = rdata_q;
  assign port_astb_n   = astb_n_q;
  assign port_dstb_n   = dstb_n_q;
  assign port_write_n  = write_n_q;
  assign port_data_oe  = oe_q;
  assign port_data_out = dout_q;
  assign port_ctrl     = ctrl_q;

  // R3: strobes are mutually exclusive
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    port_astb_n || port_dstb_n);

  // R2: register offsets finish next cycle with no strobe
  assert_plain_quick_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (state_q == ST_IDLE && bus_req && !is_hs_offs(bus_offs))
      |=> (bus_ack && port_astb_n && port_dstb_n));

  // R4: a strobe falls only after Wait was seen low
  assert_strobe_after_wait_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(port_astb_n && port_dstb_n) |-> $past(!wait_s));

  // R5: acknowledge only with both strobes released, single cycle
  assert_ack_released_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_ack |-> (port_astb_n && port_dstb_n));
  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    bus_ack |=> !bus_ack);

  // R6: direction and data steady while a strobe is low
  assert_write_steady_R6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!(port_astb_n && port_dstb_n) && $past(!(port_astb_n && port_dstb_n)))
      |-> ($stable(port_write_n) && $stable(port_data_out) && $stable(port_data_oe)));

endmodule

// File: tb/epp_host_port_tb.sv
module epp_host_port_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int TMO        = 40;

  logic          clk;
  logic          rst_n;
  logic          bus_req;
  logic          bus_we;
  logic [2:0]    bus_offs;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic          bus_ack;
  logic [DW-1:0] port_data_out;
  logic          port_data_oe;
  logic [DW-1:0] port_data_in;
  logic [DW-4:0] port_stat_in;
  logic [DW-1:0] port_ctrl;
  logic          port_wait;
  logic          port_write_n;
  logic          port_astb_n;
  logic          port_dstb_n;

  int n_checks = 0;
  int n_fails  = 0;

  epp_host_port #(.DW(DW), .TIMEOUT_CYC(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_offs(bus_offs),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .port_data_out(port_data_out), .port_data_oe(port_data_oe),
    .port_data_in(port_data_in), .port_stat_in(port_stat_in),
    .port_ctrl(port_ctrl), .port_wait(port_wait),
    .port_write_n(port_write_n), .port_astb_n(port_astb_n),
    .port_dstb_n(port_dstb_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // peripheral model
  logic          mdl_en = 1'b0;
  logic          mdl_hold = 1'b0;
  int            mdl_delay = 0;
  logic [DW-1:0] mdl_resp = '0;
  logic [DW-1:0] pin_val = '0;
  int            mdl_cnt = 0;
  int            falls = 0;
  logic          prev_low = 1'b0;
  logic [DW-1:0] cap_data = '0;
  logic          cap_wn = 1'b1;
  logic          cap_addr = 1'b0;
  logic          cap_oe = 1'b0;

  initial begin
    port_wait    = 1'b0;
    port_data_in = '0;
  end

  always @(negedge clk) begin
    logic low;
    low = !port_astb_n || !port_dstb_n;
    if (low && !prev_low) begin
      falls    <= falls + 1;
      cap_data <= port_data_out;
      cap_wn   <= port_write_n;
      cap_addr <= !port_astb_n;
      cap_oe   <= port_data_oe;
    end
    prev_low <= low;
    if (!mdl_en) begin
      port_wait    <= mdl_hold;
      port_data_in <= pin_val;
    end else if (low) begin
      if (mdl_cnt >= mdl_delay) begin
        port_wait    <= 1'b1;
        port_data_in <= mdl_resp;
      end else begin
        mdl_cnt <= mdl_cnt + 1;
      end
    end else begin
      port_wait    <= 1'b0;
      mdl_cnt      <= 0;
      port_data_in <= pin_val;
    end
  end

  int            lat;
  logic [DW-1:0] rd;
  logic          ack_strobes_hi;

  task automatic xfer(input logic [2:0] offs, input logic we, input logic [DW-1:0] wd);
    repeat (3) @(negedge clk);
    bus_req   = 1'b1;
    bus_offs  = offs;
    bus_we    = we;
    bus_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!bus_ack && lat < 10000);
    rd             = bus_rdata;
    ack_strobes_hi = port_astb_n && port_dstb_n;
    bus_req        = 1'b0;
    @(negedge clk);
    check(!bus_ack, "R5 ack single cycle", bus_ack, 0);
  endtask

  initial begin
    int base_falls;
    int lat0;
    bus_req = 0; bus_we = 0; bus_offs = 0; bus_wdata = 0; port_stat_in = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    check(port_astb_n && port_dstb_n && port_write_n, "R1 lines idle in reset",
          {port_astb_n, port_dstb_n, port_write_n}, 7);
    check(!bus_ack, "R1 ack low in reset", bus_ack, 0);
    check(port_ctrl == 0, "R1 ctrl zero in reset", port_ctrl, 0);
    check(!port_data_oe, "R1 oe low in reset", port_data_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b0, "R1 timeout flag clear after reset", rd[0], 0);

    // R11 control register sweep
    for (int v = 0; v < 256; v++) begin
      xfer(3'd2, 1'b1, DW'(v));
      check(port_ctrl == DW'(v), "R11 ctrl pins", port_ctrl, v);
      xfer(3'd2, 1'b0, 0);
      check(rd == DW'(v), "R11 ctrl readback", rd, v);
    end
    xfer(3'd2, 1'b1, 8'h00);
    xfer(3'd0, 1'b1, 8'hA5);
    repeat (2) @(negedge clk);
    check(port_data_out == 8'hA5 && port_data_oe, "R11 latch driven when idle",
          {port_data_oe, port_data_out}, 9'h1A5);
    xfer(3'd2, 1'b1, 8'h20);
    repeat (2) @(negedge clk);
    check(!port_data_oe, "R11 direction bit 5 disables output", port_data_oe, 0);
    xfer(3'd2, 1'b1, 8'h00);

    // R2 plain offsets
    base_falls = falls;
    for (int v = 0; v < 256; v += 17) begin
      pin_val = DW'(v);
      repeat (4) @(negedge clk);
      xfer(3'd0, 1'b0, 0);
      check(rd == DW'(v), "R2 offset0 reads pins", rd, v);
      check(lat == 1, "R2 offset0 latency", lat, 1);
    end
    for (int o = 5; o < 8; o++) begin
      xfer(3'(o), 1'b1, 8'hFF);
      check(lat == 1, "R2 unused write latency", lat, 1);
      xfer(3'(o), 1'b0, 0);
      check(rd == 0, "R2 unused offset reads zero", rd, 0);
    end
    xfer(3'd2, 1'b0, 0);
    check(rd == 0, "R2 unused writes left ctrl alone", rd, 0);
    check(falls == base_falls, "R2 no strobe for plain offsets", falls, base_falls);

    // R3 R6 handshake writes, every byte on both strobes
    mdl_en = 1'b1; mdl_delay = 2;
    for (int v = 0; v < 256; v++) begin
      base_falls = falls;
      xfer(3'd4, 1'b1, DW'(v));
      check(falls == base_falls + 1, "R3 one strobe per data write", falls, base_falls + 1);
      check(!cap_addr && !cap_wn, "R3 data strobe with write low", {cap_addr, cap_wn}, 0);
      check(cap_data == DW'(v) && cap_oe, "R6 write data on pins", {cap_oe, cap_data}, 256 + v);
      check(ack_strobes_hi, "R5 strobes high at ack", ack_strobes_hi, 1);
      xfer(3'd3, 1'b1, DW'(255 - v));
      check(cap_addr && !cap_wn, "R3 address strobe with write low", {cap_addr, cap_wn}, 2);
      check(cap_data == DW'(255 - v), "R6 address write data", cap_data, 255 - v);
    end

    // R7 handshake reads
    for (int v = 0; v < 256; v++) begin
      mdl_resp = DW'(v ^ 8'h3C);
      xfer(3'd3, 1'b0, 0);
      check(rd == DW'(v ^ 8'h3C), "R7 address read data", rd, v ^ 8'h3C);
      check(cap_addr && cap_wn && !cap_oe, "R3 address read lines",
            {cap_addr, cap_wn, cap_oe}, 6);
      mdl_resp = DW'(v);
      xfer(3'd4, 1'b0, 0);
      check(rd == DW'(v), "R7 data read data", rd, v);
      check(!cap_addr && cap_wn, "R3 data read lines", {cap_addr, cap_wn}, 1);
    end

    // R8 stretching
    mdl_delay = 0; mdl_resp = 8'h5A;
    xfer(3'd4, 1'b0, 0);
    lat0 = lat;
    for (int d = 1; d <= 25; d += 4) begin
      mdl_delay = d;
      xfer(3'd4, 1'b0, 0);
      check(lat == lat0 + d, "R8 ack delayed by wait delay", lat, lat0 + d);
      check(rd == 8'h5A, "R8 stretched read data", rd, 8'h5A);
    end
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b0, "R8 no timeout on stretched cycles", rd[0], 0);

    // R4 R9 watchdog with Wait stuck high
    mdl_en = 1'b0; mdl_hold = 1'b1;
    repeat (4) @(negedge clk);
    base_falls = falls;
    xfer(3'd4, 1'b0, 0);
    check(lat == TMO + 2, "R9 abort latency", lat, TMO + 2);
    check(rd == 8'hFF, "R9 aborted read all ones", rd, 8'hFF);
    check(falls == base_falls, "R4 no strobe while Wait high", falls, base_falls);
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b1, "R9 timeout flag set", rd[0], 1);
    xfer(3'd1, 1'b1, 8'h00);
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b1, "R10 writing 0 keeps flag", rd[0], 1);
    xfer(3'd1, 1'b1, 8'h01);
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b0, "R10 writing 1 clears flag", rd[0], 0);

    // R9 watchdog with Wait stuck low
    mdl_hold = 1'b0;
    repeat (4) @(negedge clk);
    base_falls = falls;
    xfer(3'd3, 1'b1, 8'h77);
    check(lat == TMO + 2, "R9 abort latency strobe low", lat, TMO + 2);
    check(falls == base_falls + 1, "R9 strobe issued before abort", falls, base_falls + 1);
    check(ack_strobes_hi, "R5 strobes released on abort", ack_strobes_hi, 1);
    xfer(3'd1, 1'b0, 0);
    check(rd[0] == 1'b1, "R9 flag after write abort", rd[0], 1);
    xfer(3'd1, 1'b1, 8'h01);

    // R10 status pins
    for (int s = 0; s < 32; s++) begin
      port_stat_in = 5'(s);
      repeat (4) @(negedge clk);
      xfer(3'd1, 1'b0, 0);
      check(rd == DW'(s << 3), "R10 status layout", rd, s << 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule